// File: doc/BRIEF.md
# Preamble Detection Qualifier

This block sits behind a symbol-rate correlator in a receiver and decides when a preamble is present. Once per symbol period it takes one correlation result: a time index, a frequency-offset index, a peak magnitude and a reference level. Each result is first judged on its own merits: the peak must clear a scaled copy of the reference, and the frequency offset must be enabled. The result then enters a short sliding window. The window as a whole must meet a similarity rule: all qualifying entries must sit within a programmable spread in time index and in frequency index.

Two window rules are selectable. The strict rule needs four clean results in a row. The tolerant rule accepts any four of the last five results, so one corrupted symbol is forgiven. Once a preamble is declared, the block raises its flag and runs a start-of-frame-delimiter search timer in symbols. An SFD-hit pulse from the downstream matcher ends the search with a one-cycle found pulse, and the block then idles. If the limit runs out first, the flag drops and the search begins again from an empty window. All settings are static configuration inputs.

Top module: `preamble_qualifier`

## Requirements
- R1: After reset `preamble_o` and `sfd_found_o` are 0 and the window is empty.
- R2: With `cfg_mode_i`=1, the flag rises in the second cycle after the fourth consecutive qualifying symbol is accepted. A non-qualifying symbol among the last four blocks detection.
- R3: With `cfg_mode_i`=0, any four qualifying, mutually similar symbols among the last five accepted give detection, and one bad symbol anywhere in the window is tolerated. Four valid symbols are enough when fewer than five have arrived.
- R4: The time indices of the four symbols used must satisfy max − min ≤ `cfg_time_span_i`. A spread one larger fails.
- R5: The frequency indices of the four symbols used must satisfy max − min ≤ `cfg_freq_span_i`.
- R6: A symbol qualifies only if peak·16 > ref·(16 + `cfg_scale_i`), that is, if it exceeds ref·(1 + scale/16) strictly. Equality fails.
- R7: Bit i of `cfg_freq_en_i` enables frequency index i (0..14). A symbol with a disabled index, or with index 15, never qualifies.
- R8: While the flag is high, each accepted symbol advances a counter. On the symbol that brings the count to `cfg_sfd_limit_i` (a limit of 0 acts as 1) with no SFD hit, the flag clears and the window is flushed. Detection then needs a fresh set of symbols.
- R9: `sfd_hit_i` while the flag is high gives one cycle of `sfd_found_o` on the next edge, clears the flag and the window, and holds the block idle. An idle block ignores symbols.
- R10: `restart_i` returns the block from any state to the search with an empty window and the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | One correlation result is present this cycle |
| sym_time_i | input | TIME_W | Time index of the correlation peak |
| sym_freq_i | input | FREQ_W | Frequency-offset index of the peak |
| sym_peak_i | input | PEAK_W | Peak magnitude |
| sym_ref_i | input | PEAK_W | Reference level for the threshold |
| cfg_mode_i | input | 1 | 0: any four of five; 1: four of four |
| cfg_time_span_i | input | 6 | Largest allowed time-index spread |
| cfg_freq_span_i | input | 4 | Largest allowed frequency-index spread |
| cfg_scale_i | input | 4 | Threshold fraction in sixteenths above 1 |
| cfg_freq_en_i | input | N_FREQ | Per-offset enable mask |
| cfg_sfd_limit_i | input | 4 | SFD search length in symbols |
| sfd_hit_i | input | 1 | SFD matched downstream |
| restart_i | input | 1 | Return to preamble search |
| preamble_o | output | 1 | Preamble detected, SFD search running |
| sfd_found_o | output | 1 | One-cycle pulse when the SFD arrives during the search |

## Verification
The bench aims at the edges of every similarity test. It uses a time spread exactly at the limit and one above it, frequency spreads of one and two, and a peak exactly at the scaled threshold and one count above it. A design with an off-by-one or non-strict comparison would declare detection one case too early or too late. In the tolerant mode it places a lone outlier in the middle of the window and two bad symbols spaced apart. A design that only dropped the oldest entry, or that counted the bad ones, would miss the first case or fire on the second. The SFD search is run to its limit, then followed by only three clean symbols. A design that kept stale window contents would fire again at once. After an SFD hit it sends symbols to the idle block, which must stay silent until restarted.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int WIN_LEN  = 5;   // tolerant window depth
  localparam int NEED     = 4;   // symbols that must agree
  localparam int SPAN_T_W = 6;
  localparam int SPAN_F_W = 4;
  localparam int SCALE_W  = 4;
  localparam int LIMIT_W  = 4;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_WAIT   = 2'd1,
    ST_IDLE   = 2'd2
  } pq_state_e;
endpackage

// File: rtl/pq_intake.sv
module pq_intake
  import pq_pkg::*;
#(
  parameter int FREQ_W = 4,
  parameter int PEAK_W = 12,
  parameter int N_FREQ = 15
) (
  input  logic [FREQ_W-1:0]  freq_i,
  input  logic [PEAK_W-1:0]  peak_i,
  input  logic [PEAK_W-1:0]  ref_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [N_FREQ-1:0]  freq_en_i,
  output logic               ok_o
);
  localparam int PAD_W  = 1 << FREQ_W;
  localparam int PROD_W = PEAK_W + SCALE_W + 1;

  logic [PAD_W-1:0]  en_pad;
  logic [PROD_W-1:0] lhs, rhs;

  // indices beyond N_FREQ read as disabled
  assign en_pad = PAD_W'(freq_en_i);
  // peak*16 vs ref*(16+scale): fraction without a divider
  assign lhs    = PROD_W'(peak_i) << SCALE_W;
  assign rhs    = PROD_W'(ref_i) * PROD_W'({1'b1, scale_i});
  assign ok_o   = en_pad[freq_i] && (lhs > rhs);
endmodule

// File: rtl/pq_window.sv
module pq_window
  import pq_pkg::*;
#(
  parameter int TIME_W = 6,
  parameter int FREQ_W = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             flush_i,
  input  logic                             push_i,
  input  logic                             ok_i,
  input  logic [TIME_W-1:0]                t_i,
  input  logic [FREQ_W-1:0]                f_i,
  output logic [WIN_LEN-1:0]               vld_o,
  output logic [WIN_LEN-1:0]               ok_o,
  output logic [WIN_LEN-1:0][TIME_W-1:0]   t_o,
  output logic [WIN_LEN-1:0][FREQ_W-1:0]   f_o
);
  logic [WIN_LEN-1:0]             vld_q, ok_q;
  logic [WIN_LEN-1:0][TIME_W-1:0] t_q;
  logic [WIN_LEN-1:0][FREQ_W-1:0] f_q;

  // slot 0 newest, slot WIN_LEN-1 oldest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ok_q  <= '0;
      t_q   <= '0;
      f_q   <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
      ok_q  <= '0;
    end else if (push_i) begin
      vld_q <= {vld_q[WIN_LEN-2:0], 1'b1};
      ok_q  <= {ok_q[WIN_LEN-2:0], ok_i};
      t_q   <= {t_q[WIN_LEN-2:0], t_i};
      f_q   <= {f_q[WIN_LEN-2:0], f_i};
    end
  end

  assign vld_o = vld_q;
  assign ok_o  = ok_q;
  assign t_o   = t_q;
  assign f_o   = f_q;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_o == '0)); // R8
  AST_PUSH_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |=> (vld_o[0] && ok_o[0] == $past(ok_i) && t_o[0] == $past(t_i))); // R2
endmodule

// File: rtl/pq_subset_check.sv
module pq_subset_check
  import pq_pkg::*;
#(
  parameter int TIME_W = 6,
  parameter int FREQ_W = 4
) (
  input  logic [NEED-1:0]              vld_i,
  input  logic [NEED-1:0]              ok_i,
  input  logic [NEED-1:0][TIME_W-1:0]  t_i,
  input  logic [NEED-1:0][FREQ_W-1:0]  f_i,
  input  logic [SPAN_T_W-1:0]          span_t_i,
  input  logic [SPAN_F_W-1:0]          span_f_i,
  output logic                         pass_o
);
  localparam int TD_W = (TIME_W > SPAN_T_W) ? TIME_W : SPAN_T_W;
  localparam int FD_W = (FREQ_W > SPAN_F_W) ? FREQ_W : SPAN_F_W;

  logic [TIME_W-1:0] t_min, t_max;
  logic [FREQ_W-1:0] f_min, f_max;
  logic [TD_W-1:0]   t_spread;
  logic [FD_W-1:0]   f_spread;

  always_comb begin
    t_min = t_i[0];
    t_max = t_i[0];
    f_min = f_i[0];
    f_max = f_i[0];
    for (int k = 1; k < NEED; k++) begin
      if (t_i[k] < t_min) t_min = t_i[k];
      if (t_i[k] > t_max) t_max = t_i[k];
      if (f_i[k] < f_min) f_min = f_i[k];
      if (f_i[k] > f_max) f_max = f_i[k];
    end
  end

  assign t_spread = TD_W'(t_max) - TD_W'(t_min);
  assign f_spread = FD_W'(f_max) - FD_W'(f_min);
  assign pass_o   = (&(vld_i & ok_i)) &&
                    (t_spread <= TD_W'(span_t_i)) &&
                    (f_spread <= FD_W'(span_f_i));
endmodule

// File: rtl/pq_sfd_ctrl.sv
module pq_sfd_ctrl
  import pq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               qualify_i,
  input  logic               sym_valid_i,
  input  logic               sfd_hit_i,
  input  logic               restart_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               accept_o,
  output logic               flush_o,
  output logic               det_o,
  output logic               sfd_found_o
);
  localparam int CNT_W = LIMIT_W + 1;

  pq_state_e        state_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             sfd_q, in_wait, timeout;

  assign in_wait  = (state_q == ST_WAIT);
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign timeout  = in_wait && sym_valid_i && !sfd_hit_i && (cnt_inc >= {1'b0, limit_i});
  assign accept_o = sym_valid_i && (state_q == ST_SEARCH);
  assign flush_o  = restart_i || (in_wait && (sfd_hit_i || timeout));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEARCH;
      cnt_q   <= '0;
      sfd_q   <= 1'b0;
    end else begin
      sfd_q <= 1'b0;
      if (restart_i) begin
        state_q <= ST_SEARCH;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_SEARCH: if (qualify_i) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
          end
          ST_WAIT: begin
            if (sfd_hit_i) begin
              state_q <= ST_IDLE;
              sfd_q   <= 1'b1;
            end else if (timeout) begin
              state_q <= ST_SEARCH;
              cnt_q   <= '0;
            end else if (sym_valid_i) begin
              cnt_q <= cnt_inc;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign det_o       = in_wait;
  assign sfd_found_o = sfd_q;

  AST_DET_NEEDS_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_o) |-> $past(qualify_i)); // R2
  AST_SFD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfd_found_o |=> !sfd_found_o); // R9
  AST_SFD_FROM_SEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfd_found_o |-> $past(det_o && sfd_hit_i)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !restart_i) |=> !det_o); // R9
  AST_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(det_o) |-> $past(sfd_hit_i || sym_valid_i || restart_i)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |-> !cnt_q[LIMIT_W]); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!det_o && !sfd_found_o)); // R10
endmodule

// File: rtl/preamble_qualifier.sv
module preamble_qualifier
  import pq_pkg::*;
#(
  parameter int TIME_W = 6,
  parameter int FREQ_W = 4,
  parameter int PEAK_W = 12,
  parameter int N_FREQ = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sym_valid_i,
  input  logic [TIME_W-1:0]   sym_time_i,
  input  logic [FREQ_W-1:0]   sym_freq_i,
  input  logic [PEAK_W-1:0]   sym_peak_i,
  input  logic [PEAK_W-1:0]   sym_ref_i,
  input  logic                cfg_mode_i,
  input  logic [SPAN_T_W-1:0] cfg_time_span_i,
  input  logic [SPAN_F_W-1:0] cfg_freq_span_i,
  input  logic [SCALE_W-1:0]  cfg_scale_i,
  input  logic [N_FREQ-1:0]   cfg_freq_en_i,
  input  logic [LIMIT_W-1:0]  cfg_sfd_limit_i,
  input  logic                sfd_hit_i,
  input  logic                restart_i,
  output logic                preamble_o,
  output logic                sfd_found_o
);
  logic                             sym_ok, accept, flush, qualify;
  logic [WIN_LEN-1:0]               win_vld, win_ok, sub_pass;
  logic [WIN_LEN-1:0][TIME_W-1:0]   win_t;
  logic [WIN_LEN-1:0][FREQ_W-1:0]   win_f;

  pq_intake #(.FREQ_W(FREQ_W), .PEAK_W(PEAK_W), .N_FREQ(N_FREQ)) u_intake (
    .freq_i    (sym_freq_i),
    .peak_i    (sym_peak_i),
    .ref_i     (sym_ref_i),
    .scale_i   (cfg_scale_i),
    .freq_en_i (cfg_freq_en_i),
    .ok_o      (sym_ok)
  );

  pq_window #(.TIME_W(TIME_W), .FREQ_W(FREQ_W)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (accept),
    .ok_i    (sym_ok),
    .t_i     (sym_time_i),
    .f_i     (sym_freq_i),
    .vld_o   (win_vld),
    .ok_o    (win_ok),
    .t_o     (win_t),
    .f_o     (win_f)
  );

  // one checker per leave-one-out subset; subset WIN_LEN-1 drops the oldest
  for (genvar j = 0; j < WIN_LEN; j++) begin : g_sub
    logic [NEED-1:0]             s_vld, s_ok;
    logic [NEED-1:0][TIME_W-1:0] s_t;
    logic [NEED-1:0][FREQ_W-1:0] s_f;
    for (genvar k = 0; k < NEED; k++) begin : g_pick
      localparam int SLOT = (k < j) ? k : k + 1;
      assign s_vld[k] = win_vld[SLOT];
      assign s_ok[k]  = win_ok[SLOT];
      assign s_t[k]   = win_t[SLOT];
      assign s_f[k]   = win_f[SLOT];
    end
    pq_subset_check #(.TIME_W(TIME_W), .FREQ_W(FREQ_W)) u_chk (
      .vld_i    (s_vld),
      .ok_i     (s_ok),
      .t_i      (s_t),
      .f_i      (s_f),
      .span_t_i (cfg_time_span_i),
      .span_f_i (cfg_freq_span_i),
      .pass_o   (sub_pass[j])
    );
  end

  assign qualify = cfg_mode_i ? sub_pass[WIN_LEN-1] : (|sub_pass);

  pq_sfd_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .qualify_i   (qualify),
    .sym_valid_i (sym_valid_i),
    .sfd_hit_i   (sfd_hit_i),
    .restart_i   (restart_i),
    .limit_i     (cfg_sfd_limit_i),
    .accept_o    (accept),
    .flush_o     (flush),
    .det_o       (preamble_o),
    .sfd_found_o (sfd_found_o)
  );

  AST_STRICT_NEEDS_FOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i && qualify) |-> (&win_vld[NEED-1:0])); // R2
  AST_TOLERANT_NEEDS_FOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qualify |-> ($countones(win_vld & win_ok) >= NEED)); // R3
endmodule

// File: tb/preamble_qualifier_tb.sv
`timescale 1ns/1ps
module preamble_qualifier_tb_top;
  localparam int TIME_W = 6;
  localparam int FREQ_W = 4;
  localparam int PEAK_W = 12;
  localparam int N_FREQ = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0;
  logic [TIME_W-1:0] sym_time = '0;
  logic [FREQ_W-1:0] sym_freq = '0;
  logic [PEAK_W-1:0] sym_peak = '0;
  logic [PEAK_W-1:0] sym_ref = 12'd100;
  logic cfg_mode = 1'b1;
  logic [5:0] cfg_tspan = 6'd3;
  logic [3:0] cfg_fspan = 4'd1;
  logic [3:0] cfg_scale = 4'd8;
  logic [N_FREQ-1:0] cfg_en = '1;
  logic [3:0] cfg_limit = 4'd8;
  logic sfd_hit = 1'b0;
  logic restart = 1'b0;
  logic preamble;
  logic sfd_found;

  always #2 clk = ~clk;

  preamble_qualifier #(.TIME_W(TIME_W), .FREQ_W(FREQ_W), .PEAK_W(PEAK_W), .N_FREQ(N_FREQ)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .sym_valid_i (sym_valid), .sym_time_i (sym_time),
    .sym_freq_i (sym_freq), .sym_peak_i (sym_peak), .sym_ref_i (sym_ref),
    .cfg_mode_i (cfg_mode), .cfg_time_span_i (cfg_tspan), .cfg_freq_span_i (cfg_fspan),
    .cfg_scale_i (cfg_scale), .cfg_freq_en_i (cfg_en), .cfg_sfd_limit_i (cfg_limit),
    .sfd_hit_i (sfd_hit), .restart_i (restart), .preamble_o (preamble), .sfd_found_o (sfd_found)
  );

  typedef struct {
    bit    chk_det;
    bit    exp_det;
    bit    exp_sfd;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  event chk_ev;
  int   n_checks = 0;
  int   n_err = 0;
  bit   finished = 0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        if (it.chk_det) begin
          n_checks++;
          if (preamble !== it.exp_det) begin
            n_err++;
            $display("FAIL %s: preamble_o=%0b expected %0b", it.tag, preamble, it.exp_det);
          end
        end
        n_checks++;
        if (sfd_found !== it.exp_sfd) begin
          n_err++;
          $display("FAIL %s: sfd_found_o=%0b expected %0b", it.tag, sfd_found, it.exp_sfd);
        end
      end
    end
  end

  task automatic expect_now(input bit chk_det, input bit exp_det, input bit exp_sfd, input string tag);
    exp_t it;
    it.chk_det = chk_det;
    it.exp_det = exp_det;
    it.exp_sfd = exp_sfd;
    it.tag     = tag;
    sb_q.push_back(it);
    ->chk_ev;
  endtask

  // one symbol: accepted on the first edge, flag settles after the second
  task automatic sym(input int t, input int f, input int pk, input bit exp_det, input string tag);
    sym_valid = 1'b1;
    sym_time  = TIME_W'(t);
    sym_freq  = FREQ_W'(f);
    sym_peak  = PEAK_W'(pk);
    @(negedge clk);
    sym_valid = 1'b0;
    expect_now(1'b0, 1'b0, 1'b0, tag);
    @(negedge clk);
    expect_now(1'b1, exp_det, 1'b0, tag);
  endtask

  task automatic good(input bit exp_det, input string tag);
    sym(10, 5, 200, exp_det, tag);
  endtask

  task automatic bad(input bit exp_det, input string tag);
    sym(10, 5, 10, exp_det, tag);
  endtask

  task automatic do_restart(input string tag);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    expect_now(1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic do_sfd(input bit exp_pulse, input string tag);
    sfd_hit = 1'b1;
    @(negedge clk);
    sfd_hit = 1'b0;
    expect_now(1'b1, 1'b0, exp_pulse, tag);
    @(negedge clk);
    expect_now(1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now(1'b1, 1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_now(1'b1, 1'b0, 1'b0, "R1 after reset");

    // R2 strict mode: three are not enough, the fourth fires
    good(0, "R2 sym1"); good(0, "R2 sym2"); good(0, "R2 sym3"); good(1, "R2 sym4");
    // R9 SFD found, then idle ignores symbols
    do_sfd(1'b1, "R9 sfd pulse");
    good(0, "R9 idle"); good(0, "R9 idle"); good(0, "R9 idle"); good(0, "R9 idle");
    good(0, "R9 idle");
    // R10 restart from idle
    do_restart("R10 from idle");
    good(0, "R10 s1"); good(0, "R10 s2"); good(0, "R10 s3"); good(1, "R10 s4");
    // R8 timeout at limit 8
    for (int i = 1; i < 8; i++) good(1, "R8 wait");
    good(0, "R8 limit reached");
    good(0, "R8 flushed 1"); good(0, "R8 flushed 2"); good(0, "R8 flushed 3");
    good(1, "R8 redetect");
    do_restart("R10 from wait");
    good(0, "R10 fresh");

    // R2 strict mode rejects one bad symbol
    do_restart("R2 prep");
    good(0, "R2 g"); good(0, "R2 g"); bad(0, "R2 b"); good(0, "R2 g"); good(0, "R2 g");
    good(0, "R2 bad still in last four"); good(1, "R2 four clean");

    // R4 time spread at limit and above
    do_restart("R4 prep");
    sym(10, 5, 200, 0, "R4"); sym(11, 5, 200, 0, "R4"); sym(13, 5, 200, 0, "R4");
    sym(12, 5, 200, 1, "R4 spread 3");
    do_restart("R4 prep");
    sym(10, 5, 200, 0, "R4"); sym(11, 5, 200, 0, "R4"); sym(14, 5, 200, 0, "R4");
    sym(12, 5, 200, 0, "R4 spread 4");

    // R5 frequency spread
    do_restart("R5 prep");
    sym(10, 5, 200, 0, "R5"); sym(10, 6, 200, 0, "R5"); sym(10, 5, 200, 0, "R5");
    sym(10, 6, 200, 1, "R5 spread 1");
    do_restart("R5 prep");
    sym(10, 5, 200, 0, "R5"); sym(10, 7, 200, 0, "R5"); sym(10, 6, 200, 0, "R5");
    sym(10, 6, 200, 0, "R5 spread 2");

    // R6 threshold: ref 100, scale 8 -> must exceed 150
    do_restart("R6 prep");
    sym(10, 5, 151, 0, "R6"); sym(10, 5, 151, 0, "R6"); sym(10, 5, 150, 0, "R6");
    sym(10, 5, 151, 0, "R6 equality fails");
    do_restart("R6 prep");
    sym(10, 5, 151, 0, "R6"); sym(10, 5, 151, 0, "R6"); sym(10, 5, 151, 0, "R6");
    sym(10, 5, 151, 1, "R6 just above");
    cfg_scale = 4'd0;
    do_restart("R6 prep");
    sym(10, 5, 101, 0, "R6"); sym(10, 5, 101, 0, "R6"); sym(10, 5, 101, 0, "R6");
    sym(10, 5, 101, 1, "R6 unity scale");
    cfg_scale = 4'd8;

    // R7 frequency mask
    cfg_en[5] = 1'b0;
    do_restart("R7 prep");
    good(0, "R7 masked"); good(0, "R7 masked"); good(0, "R7 masked"); good(0, "R7 masked");
    cfg_en = '1;
    do_restart("R7 prep");
    sym(10, 15, 200, 0, "R7 idx15"); sym(10, 15, 200, 0, "R7 idx15");
    sym(10, 15, 200, 0, "R7 idx15"); sym(10, 15, 200, 0, "R7 idx15");

    // R3 tolerant mode
    cfg_mode = 1'b0;
    do_restart("R3 prep");
    good(0, "R3"); bad(0, "R3"); good(0, "R3"); good(0, "R3"); good(1, "R3 one bad tolerated");
    do_restart("R3 prep");
    good(0, "R3"); bad(0, "R3"); good(0, "R3"); bad(0, "R3"); good(0, "R3 three of five");
    good(0, "R3 two bad"); good(1, "R3 four of five");
    do_restart("R3 prep");
    sym(10, 5, 200, 0, "R3"); sym(10, 5, 200, 0, "R3"); sym(30, 5, 200, 0, "R3");
    sym(10, 5, 200, 0, "R3 outlier in four"); sym(10, 5, 200, 1, "R3 outlier dropped");
    do_restart("R3 prep");
    good(0, "R3"); good(0, "R3"); good(0, "R3"); good(1, "R3 four valid only");

    // R8 small limit and zero limit
    cfg_limit = 4'd2;
    good(1, "R8 lim2 first"); good(0, "R8 lim2 second");
    cfg_limit = 4'd0;
    good(0, "R8 lim0 f1"); good(0, "R8 lim0 f2"); good(0, "R8 lim0 f3"); good(1, "R8 lim0 det");
    good(0, "R8 lim0 acts as 1");
    cfg_limit = 4'd8;

    // R9 SFD hit outside the search gives no pulse
    do_restart("R9 prep");
    do_sfd(1'b0, "R9 no pulse while searching");

    finished = 1;
    @(negedge clk);
    report();
  end
endmodule